// File: doc/BRIEF.md
# Alternating-Gate Frequency Error Counter

This block produces the gating and channel steering for a counter that measures the frequency offset of an unknown signal against a reference. One of several time-base tick lines is picked by a range code. The ticks on that line are divided by ten to form each measurement window. Between windows the gate shuts for exactly one time-base tick. The channel flag flips each time the gate shuts, so successive windows count the unknown input and then the reference input.

In audio mode the unknown window counts up and the reference window counts down, both into one signed saturating accumulator. At the end of each pair of windows the accumulator holds unknown minus reference. It is published with a one-cycle valid strobe and then cleared. In carrier mode the carrier input is counted upward in every window, whatever the channel flag says, and each window publishes its own count.

All signal inputs are single-cycle pulses that are already synchronous to the system clock. The range code and the mode bit are sampled only when the gate reopens after an inhibit gap. If either has changed, the accumulator is cleared and the channel flag restarts at the unknown side, so no result ever mixes two settings.

Top module: `alt_gate_freq_err`

## Requirements
- R1: The tick line indexed by the range code (value k selects `tb_tick[k]`) is the only time-base source. Pulses on the other tick lines neither advance a window nor reopen the gate.
- R2: Once open, the gate (`gate_open` = 1) stays open for exactly ten ticks of the selected line and shuts on the tenth. The following selected tick reopens it, so the inhibit gap lasts one tick.
- R3: `chan_ref` inverts at every transition of the gate from open to shut and is constant while the gate is open. 0 selects the unknown input and 1 selects the reference input.
- R4: When the latched mode bit is 1 (carrier), only `car_pulse` is counted, always upward, in every window. `unk_pulse` and `ref_pulse` are ignored.
- R5: A pulse is counted only while the gate is open. `cnt_up` flags an upward count (unknown in audio mode, carrier in carrier mode). `cnt_dn` flags a downward count (reference in audio mode). No count happens during inhibit.
- R6: In audio mode, `result` takes the accumulated unknown-minus-reference value on the tick that ends a reference window. In carrier mode it takes the window count on the tick that ends every window. `result_valid` is high for that one cycle only, and the accumulator restarts at zero.
- R7: The accumulator is signed, ACC_W bits wide, and saturates at the largest positive and the most negative value instead of wrapping.
- R8: A synchronous reset shuts the gate, clears `chan_ref`, the accumulator, `result` and `result_valid`, and primes the divider so that the first selected tick opens the gate.
- R9: `range_sel` and `mode_rf` take effect only on the tick that reopens the gate. A changed setting clears the accumulator and forces `chan_ref` to 0. A change made while the gate is open does not alter that window's counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_tick | input | NUM_TB | One tick-enable pulse line per time-base rate |
| range_sel | input | $clog2(NUM_TB) | Index of the tick line to use |
| mode_rf | input | 1 | 1: count carrier; 0: alternate unknown and reference |
| unk_pulse | input | 1 | Edge pulse of the unknown signal |
| ref_pulse | input | 1 | Edge pulse of the reference signal |
| car_pulse | input | 1 | Edge pulse of the demodulated carrier |
| gate_open | output | 1 | 1 while a measurement window is open, 0 during inhibit |
| chan_ref | output | 1 | Channel flag: 0 unknown, 1 reference |
| cnt_up | output | 1 | A pulse is being counted upward this cycle |
| cnt_dn | output | 1 | A pulse is being counted downward this cycle |
| result | output | ACC_W | Signed result of the last completed measurement |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The bench builds the block with ACC_W = 4, so the accumulator spans -8 to 7. A window of up to ten pulses can then drive it into both saturation limits. It can also show that saturation has memory: ten unknown pulses followed by three reference pulses give 4, not 7. DIV_N stays at ten and NUM_TB at four. Every window therefore checks the real decade length, and pulses on the three unselected tick lines can test range selection.

// File: rtl/alt_gate_freq_err.sv
`timescale 1ns/1ps
module alt_gate_freq_err #(
  parameter int ACC_W  = 24,
  parameter int DIV_N  = 10,
  parameter int NUM_TB = 4,
  localparam int SEL_W = (NUM_TB > 1) ? $clog2(NUM_TB) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_TB-1:0]       tb_tick,
  input  logic [SEL_W-1:0]        range_sel,
  input  logic                    mode_rf,
  input  logic                    unk_pulse,
  input  logic                    ref_pulse,
  input  logic                    car_pulse,
  output logic                    gate_open,
  output logic                    chan_ref,
  output logic                    cnt_up,
  output logic                    cnt_dn,
  output logic signed [ACC_W-1:0] result,
  output logic                    result_valid
);
  localparam int DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(DIV_N - 1);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(1);

  logic [DIV_W-1:0]        div_q;
  logic [SEL_W-1:0]        act_sel;
  logic                    act_rf;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_upd;

  wire sel_tick  = gate_open ? tb_tick[act_sel] : tb_tick[range_sel];
  wire term      = sel_tick && (div_q == DIV_TOP);
  wire open_now  = term && !gate_open;
  wire close_now = term && gate_open;
  wire changed   = (range_sel != act_sel) || (mode_rf != act_rf);
  wire down      = !act_rf && chan_ref;
  wire sig_pulse = act_rf ? car_pulse : (chan_ref ? ref_pulse : unk_pulse);
  wire finish    = close_now && (act_rf || chan_ref);

  assign cnt_up = gate_open && sig_pulse && !down;
  assign cnt_dn = gate_open && sig_pulse && down;

  always_comb begin
    acc_upd = acc_q;
    if (cnt_up && acc_q != ACC_MAX) acc_upd = acc_q + ONE;
    if (cnt_dn && acc_q != ACC_MIN) acc_upd = acc_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q        <= DIV_TOP;
      gate_open    <= 1'b0;
      chan_ref     <= 1'b0;
      acc_q        <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      act_sel      <= '0;
      act_rf       <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (sel_tick) div_q <= (div_q == DIV_TOP) ? '0 : div_q + 1'b1;
      if (close_now) begin
        gate_open <= 1'b0;
        div_q     <= DIV_TOP;
        chan_ref  <= !chan_ref;
        if (finish) begin
          result       <= acc_upd;
          result_valid <= 1'b1;
          acc_q        <= '0;
        end else begin
          acc_q <= acc_upd;
        end
      end else if (open_now) begin
        gate_open <= 1'b1;
        act_sel   <= range_sel;
        act_rf    <= mode_rf;
        if (changed) begin
          acc_q    <= '0;
          chan_ref <= 1'b0;
        end
      end else begin
        acc_q <= acc_upd;
      end
    end
  end

  AST_GAP_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    (!gate_open && sel_tick) |=> gate_open); // R2
  AST_CHAN_FLIP: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_open) && !$past(rst)) |-> (chan_ref != $past(chan_ref))); // R3
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (gate_open && $past(gate_open) && !$past(rst)) |-> $stable(chan_ref)); // R3
  AST_VALID_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !$past(rst)) |-> $fell(gate_open)); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid); // R6
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (acc_q == ACC_MAX && cnt_up && !close_now) |=> (acc_q == ACC_MAX)); // R7
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (acc_q == ACC_MIN && cnt_dn && !close_now) |=> (acc_q == ACC_MIN)); // R7
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!gate_open && !chan_ref && !result_valid && result == '0)); // R8
endmodule

// File: tb/alt_gate_freq_err_tb_top.sv
`timescale 1ns/1ps
module alt_gate_freq_err_tb_top;
  localparam int AW = 4;
  localparam int AMAX = 7;
  localparam int AMIN = -8;
  // fields: [14:13] range, [12] carrier mode, [11:8] unknown, [7:4] reference, [3:0] carrier
  localparam logic [14:0] VEC [9] = '{
    {2'd0, 1'b0, 4'd5,  4'd2,  4'd0},
    {2'd1, 1'b0, 4'd2,  4'd6,  4'd4},
    {2'd2, 1'b0, 4'd10, 4'd0,  4'd3},
    {2'd3, 1'b0, 4'd0,  4'd10, 4'd1},
    {2'd3, 1'b0, 4'd10, 4'd3,  4'd0},
    {2'd0, 1'b1, 4'd4,  4'd2,  4'd6},
    {2'd0, 1'b1, 4'd3,  4'd3,  4'd9},
    {2'd1, 1'b1, 4'd0,  4'd0,  4'd0},
    {2'd2, 1'b0, 4'd7,  4'd7,  4'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] tb_tick = '0;
  logic [1:0] range_sel = '0;
  logic mode_rf = 1'b0, unk_pulse = 1'b0, ref_pulse = 1'b0, car_pulse = 1'b0;
  logic gate_open, chan_ref, cnt_up, cnt_dn, result_valid;
  logic signed [AW-1:0] result;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit ch = 1'b0, lat_rf = 1'b0;
  logic [1:0] lat_rs = '0;

  always #4 clk = !clk;

  alt_gate_freq_err #(.ACC_W(AW), .DIV_N(10), .NUM_TB(4)) dut_i (
    .clk(clk), .rst(rst), .tb_tick(tb_tick), .range_sel(range_sel), .mode_rf(mode_rf),
    .unk_pulse(unk_pulse), .ref_pulse(ref_pulse), .car_pulse(car_pulse),
    .gate_open(gate_open), .chan_ref(chan_ref), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .result(result), .result_valid(result_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pair_exp(input int nu, input int nr);
    int a = 0;
    for (int i = 0; i < nu; i++) a = (a < AMAX) ? a + 1 : a;
    for (int i = 0; i < nr; i++) a = (a > AMIN) ? a - 1 : a;
    return a;
  endfunction

  // one full window: opening tick, ten ticks with decoy ticks and pulses between
  task automatic win(input int u, input int r, input int c, input bit flip, input int exp_res);
    bit exp_up, exp_dn, exp_v;
    if (range_sel != lat_rs || mode_rf != lat_rf) ch = 1'b0;
    lat_rs = range_sel;
    lat_rf = mode_rf;
    tb_tick = 4'b0001 << range_sel;
    @(negedge clk);
    tb_tick = '0;
    chk(gate_open == 1'b1, "R2 gate opens after one-tick gap", int'(gate_open), 1);
    chk(chan_ref == ch, "R3/R9 channel at window start", int'(chan_ref), int'(ch));
    chk(result_valid == 1'b0, "R6 valid lasts one cycle", int'(result_valid), 0);
    if (flip) mode_rf = !mode_rf;
    for (int k = 1; k <= 10; k++) begin
      tb_tick = ~(4'b0001 << lat_rs);
      @(negedge clk);
      tb_tick = '0;
      unk_pulse = (k <= u);
      ref_pulse = (k <= r);
      car_pulse = (k <= c);
      exp_up = lat_rf ? (k <= c) : (!ch && k <= u);
      exp_dn = !lat_rf && ch && (k <= r);
      #1;
      chk(cnt_up == exp_up, lat_rf ? "R4 carrier counts up" : "R5 up strobe", int'(cnt_up), int'(exp_up));
      chk(cnt_dn == exp_dn, lat_rf ? "R4 no down count in carrier mode" : "R3 reference counts down",
          int'(cnt_dn), int'(exp_dn));
      @(negedge clk);
      unk_pulse = 1'b0; ref_pulse = 1'b0; car_pulse = 1'b0;
      chk(gate_open == 1'b1, "R1/R2 gate held open", int'(gate_open), 1);
      tb_tick = 4'b0001 << lat_rs;
      @(negedge clk);
      tb_tick = '0;
    end
    exp_v = lat_rf || ch;
    chk(gate_open == 1'b0, "R2 gate shuts on tenth tick", int'(gate_open), 0);
    chk(chan_ref == !ch, "R3 channel flips at inhibit", int'(chan_ref), int'(!ch));
    chk(result_valid == exp_v, "R6 result strobe", int'(result_valid), int'(exp_v));
    if (exp_v) chk(int'(result) == exp_res, "R6/R7 result value", int'(result), exp_res);
    ch = !ch;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state; R5 pulse while shut is not counted
    chk(gate_open == 1'b0, "R8 gate shut after reset", int'(gate_open), 0);
    chk(chan_ref == 1'b0, "R8 channel clear after reset", int'(chan_ref), 0);
    chk(result_valid == 1'b0 && result == '0, "R8 result clear after reset", int'(result), 0);
    unk_pulse = 1'b1; #1;
    chk(cnt_up == 1'b0, "R5 no count while shut", int'(cnt_up), 0);
    @(negedge clk); unk_pulse = 1'b0;
    tb_tick = 4'b1110; @(negedge clk); tb_tick = '0;
    chk(gate_open == 1'b0, "R1 unselected tick does not open gate", int'(gate_open), 0);

    for (int i = 0; i < 9; i++) begin
      int nu, nr, nc;
      range_sel = VEC[i][14:13];
      mode_rf   = VEC[i][12];
      nu = int'(VEC[i][11:8]);
      nr = int'(VEC[i][7:4]);
      nc = int'(VEC[i][3:0]);
      if (!VEC[i][12]) begin
        win(nu, nr, nc, 1'b0, pair_exp(nu, nr));
        win(nu, nr, nc, 1'b0, pair_exp(nu, nr));
      end else begin
        win(nu, nr, nc, 1'b0, (nc > AMAX) ? AMAX : nc);
      end
    end

    // R5: pulses in the inhibit gap are ignored
    range_sel = 2'd0; mode_rf = 1'b0;
    win(0, 0, 0, 1'b0, 0);
    win(0, 0, 0, 1'b0, 0);
    for (int k = 0; k < 3; k++) begin
      unk_pulse = 1'b1; ref_pulse = 1'b1; #1;
      chk(!cnt_up && !cnt_dn, "R5 no count in inhibit gap", int'(cnt_up), 0);
      @(negedge clk); unk_pulse = 1'b0; ref_pulse = 1'b0;
    end
    win(1, 0, 0, 1'b0, 1);
    win(1, 0, 0, 1'b0, 1);

    // R9: range change between unknown and reference windows restarts the pair
    win(3, 0, 0, 1'b0, 1);
    range_sel = 2'd1;
    win(2, 1, 0, 1'b0, 1);
    win(2, 1, 0, 1'b0, 1);

    // R9: mode change inside a window keeps that window in audio mode, then clears
    win(4, 0, 5, 1'b1, 0);
    chk(mode_rf == 1'b1, "R9 mode input flipped", int'(mode_rf), 1);
    win(4, 0, 2, 1'b0, 2);

    // R8: reset inside an open window
    range_sel = 2'd0; mode_rf = 1'b0;
    tb_tick = 4'b0001; @(negedge clk); tb_tick = '0;
    chk(gate_open == 1'b1, "R2 gate open before reset", int'(gate_open), 1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(gate_open == 1'b0 && chan_ref == 1'b0, "R8 reset shuts gate and clears channel", int'(gate_open), 0);
    chk(result == '0 && result_valid == 1'b0, "R8 reset clears result", int'(result), 0);
    lat_rs = 2'd0; lat_rf = 1'b0; ch = 1'b0;
    win(2, 1, 0, 1'b0, 1);
    win(2, 1, 0, 1'b0, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule